// File: doc/BRIEF.md
# Remote-Block Subscription Redirector

This unit sits between one near-bank compute core and the memory port of its vault. Each core request is first compared against a small, fully associative table of subscribed blocks. A request that hits is steered to the block's copy in a reserved local region. A request whose home is this vault passes through to local memory unchanged. Any other request goes out to its home vault as a remote access. The unit has a one-cycle registered latency.

Remote misses are counted per block in a small table of saturating reuse counters. When a block has been fetched remotely often enough, the unit sends out a migration request that names the block, its home vault and a free local slot. Only one migration may be in flight at a time. While it is in flight, the block is still served remotely. When the migration-complete pulse arrives, the table entry is installed and every later request to the block is redirected. An external policy enable can suppress new migrations. A flush input clears all subscriptions.

Top module: `sub_redirect_unit`

## Requirements
- R1: Every accepted request gives exactly one routed output on the next cycle. A request whose home vault equals `LOCAL_VAULT` (0) is routed local, with its address unchanged and the output vault set to 0.
- R2: A request whose block tag (address bits [23:6]) matches a valid entry is routed local. Its address becomes `RSV_BASE` (0xF00000) + slot*64 + offset, where offset is address bits [5:0].
- R3: A request that misses and whose home is another vault is routed remote, with its address unchanged and the output vault set to its home vault.
- R4: Remote misses are counted per block in 3-bit saturating counters. The access that brings a block's count to 4 or more raises a one-cycle migration request, provided subscription is enabled, no migration is in flight and a free slot exists. The request appears in the same cycle as that access's output, names the block tag and home vault, and uses the lowest-numbered free slot.
- R5: While a migration is in flight, requests to that block are still routed remote, and no further migration request is raised.
- R6: A migration-complete pulse validates the entry for the in-flight block in its slot, so the next request to that block is redirected. A pulse that arrives with nothing in flight has no effect.
- R7: While subscription is disabled, no migration request is raised. Existing entries keep redirecting, and reuse counting continues, so the first remote access after re-enabling can trigger a migration at once.
- R8: A flush pulse invalidates every entry. Later requests to formerly subscribed blocks go remote.
- R9: When the count threshold is reached with every slot valid, the entry under a round-robin pointer is invalidated and no migration is raised in that cycle. The pointer starts at 0 and advances by one on each eviction. The next qualifying access to the block then migrates it into the freed slot.
- R10: After reset, no output or migration request is valid and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_en | input | 1 | Policy enable for starting migrations |
| flush | input | 1 | Invalidate all subscription entries |
| req_valid | input | 1 | Core request valid |
| req_addr | input | 24 | Core request address |
| req_vault | input | 5 | Home vault of the requested block |
| mig_done | input | 1 | Migration-complete pulse |
| out_valid | output | 1 | Routed request valid |
| out_remote | output | 1 | 1 = to home vault, 0 = local memory |
| out_vault | output | 5 | Destination vault |
| out_addr | output | 24 | Address after redirection |
| mig_req_valid | output | 1 | Migration request pulse |
| mig_req_tag | output | 18 | Block tag to migrate |
| mig_req_vault | output | 5 | Home vault of that block |
| mig_req_slot | output | 4 | Local slot receiving the block |

## Verification
A routed output and any migration request it causes are both due at the clock edge after the request is presented. An install caused by a completion pulse takes effect for a request presented at the following edge. The bench drives each request for one cycle and queues the expected routing and migration items before it drives. A monitor compares these at the next falling edge. One time step later, the driver confirms that both queues have drained, so a late, missing or extra item is reported against the requirement being exercised.

// File: rtl/subr_pkg.sv
package subr_pkg;
    typedef enum logic [1:0] {
        ROUTE_NATIVE   = 2'd0,
        ROUTE_REDIRECT = 2'd1,
        ROUTE_REMOTE   = 2'd2
    } route_e;
endpackage

// File: rtl/subr_lookup.sv
module subr_lookup #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 18,
    parameter int SLOT_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]               key,
    input  logic [ENTRIES-1:0]             reserve,
    output logic                           hit,
    output logic [SLOT_W-1:0]              hit_idx,
    output logic                           free_ok,
    output logic [SLOT_W-1:0]              free_idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = SLOT_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i] && !reserve[i]) begin
                free_ok  = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    // a block may be subscribed in at most one slot
    assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/subr_reuse.sv
module subr_reuse #(
    parameter int CTRS  = 4,
    parameter int TAG_W = 18,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [TAG_W-1:0] key,
    input  logic             consume,
    output logic [CNT_W-1:0] cnt_new
);
    localparam int IDX_W = (CTRS > 1) ? $clog2(CTRS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CTRS-1:0]             vld;
        logic [CTRS-1:0][TAG_W-1:0]  tag;
        logic [CTRS-1:0][CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]            rr;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic             found;
    logic [IDX_W-1:0] found_idx;
    logic             empty_ok;
    logic [IDX_W-1:0] empty_idx;

    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        empty_ok  = 1'b0;
        empty_idx = '0;
        for (int i = 0; i < CTRS; i++) begin
            if (st_q.vld[i] && st_q.tag[i] == key) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
        end
        for (int i = CTRS - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                empty_ok  = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
        if (!found) cnt_new = CNT_W'(1);
        else if (st_q.cnt[found_idx] == CNT_MAX) cnt_new = CNT_MAX;
        else cnt_new = st_q.cnt[found_idx] + CNT_W'(1);
    end

    always_comb begin
        logic [IDX_W-1:0] slot;
        st_d = st_q;
        slot = empty_ok ? empty_idx : st_q.rr;
        if (upd) begin
            if (found) begin
                if (consume) st_d.vld[found_idx] = 1'b0;
                else         st_d.cnt[found_idx] = cnt_new;
            end else if (!consume) begin
                st_d.vld[slot] = 1'b1;
                st_d.tag[slot] = key;
                st_d.cnt[slot] = cnt_new;
                if (!empty_ok)
                    st_d.rr = (st_q.rr == IDX_W'(CTRS - 1)) ? '0 : st_q.rr + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a counter is only retired by an access that was itself counted
    assert_consume_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> upd);
endmodule

// File: rtl/sub_redirect_unit.sv
module sub_redirect_unit #(
    parameter int          ADDR_W      = 24,
    parameter int          OFS_W       = 6,
    parameter int          VAULT_W     = 5,
    parameter int          LOCAL_VAULT = 0,
    parameter int          ENTRIES     = 16,
    parameter int          CTRS        = 4,
    parameter int          CNT_W       = 3,
    parameter int          THRESH      = 4,
    parameter logic [23:0] RSV_BASE    = 24'hF00000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sub_en,
    input  logic                             flush,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [VAULT_W-1:0]               req_vault,
    input  logic                             mig_done,
    output logic                             out_valid,
    output logic                             out_remote,
    output logic [VAULT_W-1:0]               out_vault,
    output logic [ADDR_W-1:0]                out_addr,
    output logic                             mig_req_valid,
    output logic [ADDR_W-OFS_W-1:0]          mig_req_tag,
    output logic [VAULT_W-1:0]               mig_req_vault,
    output logic [$clog2(ENTRIES)-1:0]       mig_req_slot
);
    import subr_pkg::*;

    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int SLOT_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]               vld;
        logic [ENTRIES-1:0][TAG_W-1:0]    tag;
        logic [ENTRIES-1:0][VAULT_W-1:0]  home;
        logic                             pend;
        logic [SLOT_W-1:0]                rr;
        logic                             ov;
        logic                             orem;
        logic [VAULT_W-1:0]               ovault;
        logic [ADDR_W-1:0]                oaddr;
        logic                             mv;
        logic [TAG_W-1:0]                 mtag;
        logic [VAULT_W-1:0]               mvault;
        logic [SLOT_W-1:0]                mslot;
    } st_t;

    st_t st_d, st_q;

    logic [TAG_W-1:0]   req_tag;
    logic               hit, free_ok;
    logic [SLOT_W-1:0]  hit_idx, free_idx;
    logic [ENTRIES-1:0] reserve;
    logic               is_native, is_pend_blk, upd, hot, launch, evict;
    logic [CNT_W-1:0]   cnt_new;
    route_e             route;

    assign req_tag = req_addr[ADDR_W-1:OFS_W];
    assign reserve = st_q.pend ? (ENTRIES'(1) << st_q.mslot) : '0;

    subr_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .vld(st_q.vld), .tags(st_q.tag), .key(req_tag),
        .reserve(reserve), .hit(hit), .hit_idx(hit_idx),
        .free_ok(free_ok), .free_idx(free_idx)
    );

    subr_reuse #(.CTRS(CTRS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_reuse (
        .clk(clk), .rst_n(rst_n), .upd(upd), .key(req_tag),
        .consume(launch), .cnt_new(cnt_new)
    );

    always_comb begin
        is_native   = (req_vault == VAULT_W'(LOCAL_VAULT));
        is_pend_blk = st_q.pend && (st_q.mtag == req_tag);
        if (is_native)  route = ROUTE_NATIVE;
        else if (hit)   route = ROUTE_REDIRECT;
        else            route = ROUTE_REMOTE;
        upd    = req_valid && (route == ROUTE_REMOTE) && !is_pend_blk;
        hot    = upd && (cnt_new >= CNT_W'(THRESH)) && sub_en && !st_q.pend;
        launch = hot && free_ok;
        evict  = hot && !free_ok;
    end

    always_comb begin
        st_d    = st_q;
        st_d.ov = req_valid;
        st_d.mv = 1'b0;
        if (req_valid) begin
            unique case (route)
                ROUTE_REDIRECT: begin
                    st_d.orem   = 1'b0;
                    st_d.ovault = VAULT_W'(LOCAL_VAULT);
                    st_d.oaddr  = RSV_BASE + ADDR_W'({hit_idx, req_addr[OFS_W-1:0]});
                end
                ROUTE_REMOTE: begin
                    st_d.orem   = 1'b1;
                    st_d.ovault = req_vault;
                    st_d.oaddr  = req_addr;
                end
                default: begin
                    st_d.orem   = 1'b0;
                    st_d.ovault = VAULT_W'(LOCAL_VAULT);
                    st_d.oaddr  = req_addr;
                end
            endcase
        end
        if (launch) begin
            st_d.mv     = 1'b1;
            st_d.pend   = 1'b1;
            st_d.mtag   = req_tag;
            st_d.mvault = req_vault;
            st_d.mslot  = free_idx;
        end
        if (evict) begin
            st_d.vld[st_q.rr] = 1'b0;
            st_d.rr = (st_q.rr == SLOT_W'(ENTRIES - 1)) ? '0 : st_q.rr + SLOT_W'(1);
        end
        if (flush) st_d.vld = '0;
        if (mig_done && st_q.pend) begin
            st_d.vld[st_q.mslot]  = 1'b1;
            st_d.tag[st_q.mslot]  = st_q.mtag;
            st_d.home[st_q.mslot] = st_q.mvault;
            st_d.pend             = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.ov;
    assign out_remote    = st_q.orem;
    assign out_vault     = st_q.ovault;
    assign out_addr      = st_q.oaddr;
    assign mig_req_valid = st_q.mv;
    assign mig_req_tag   = st_q.mtag;
    assign mig_req_vault = st_q.mvault;
    assign mig_req_slot  = st_q.mslot;

    assert_one_out_per_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_no_spurious_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    assert_mig_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_req_valid) |-> $past(sub_en));
    assert_single_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req_valid |=> !mig_req_valid);
    assert_target_slot_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req_valid |-> !st_q.vld[mig_req_slot]);
endmodule

// File: tb/sim_sub_redirect_unit.sv
module sim_sub_redirect_unit;
    localparam int CLK_NS = 10;
    localparam logic [23:0] RSV = 24'hF00000;
    localparam logic [5:0]  OFF = 6'h05;

    logic        clk = 1'b0, rst_n = 1'b0, sub_en = 1'b0, flush = 1'b0;
    logic        req_valid = 1'b0, mig_done = 1'b0;
    logic [23:0] req_addr = '0;
    logic [4:0]  req_vault = '0;
    logic        out_valid, out_remote, mig_req_valid;
    logic [4:0]  out_vault, mig_req_vault;
    logic [23:0] out_addr;
    logic [17:0] mig_req_tag;
    logic [3:0]  mig_req_slot;

    sub_redirect_unit u0 (
        .clk(clk), .rst_n(rst_n), .sub_en(sub_en), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_vault(req_vault),
        .mig_done(mig_done), .out_valid(out_valid), .out_remote(out_remote),
        .out_vault(out_vault), .out_addr(out_addr), .mig_req_valid(mig_req_valid),
        .mig_req_tag(mig_req_tag), .mig_req_vault(mig_req_vault), .mig_req_slot(mig_req_slot)
    );

    typedef struct { bit rem; logic [4:0] vault; logic [23:0] addr; string req; } rt_exp_t;
    typedef struct { logic [17:0] tag; logic [4:0] vault; logic [3:0] slot; string req; } mg_exp_t;

    rt_exp_t rq[$];
    mg_exp_t mq[$];
    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // monitor: compares design results with queued expectations
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (out_valid) begin
                checks++;
                if (rq.size() == 0) begin
                    errors++;
                    $display("FAIL R1 extra output: actual addr %h expected none", out_addr);
                end else begin
                    rt_exp_t e;
                    e = rq.pop_front();
                    if (out_remote !== e.rem || out_vault !== e.vault || out_addr !== e.addr) begin
                        errors++;
                        $display("FAIL %s route: actual rem=%0d vault=%0d addr=%h expected rem=%0d vault=%0d addr=%h",
                                 e.req, out_remote, out_vault, out_addr, e.rem, e.vault, e.addr);
                    end
                end
            end
            if (mig_req_valid) begin
                checks++;
                if (mq.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected migration: actual tag=%h slot=%0d expected none",
                             mig_req_tag, mig_req_slot);
                end else begin
                    mg_exp_t m;
                    m = mq.pop_front();
                    if (mig_req_tag !== m.tag || mig_req_vault !== m.vault || mig_req_slot !== m.slot) begin
                        errors++;
                        $display("FAIL %s migration: actual tag=%h vault=%0d slot=%0d expected tag=%h vault=%0d slot=%0d",
                                 m.req, mig_req_tag, mig_req_vault, mig_req_slot, m.tag, m.vault, m.slot);
                    end
                end
            end
        end
    end

    task automatic send(input logic [17:0] tag, input logic [4:0] home, input bit rem,
                        input logic [23:0] ea, input string r);
        rq.push_back('{rem, rem ? home : 5'd0, ea, r});
        req_valid = 1'b1;
        req_addr  = {tag, OFF};
        req_vault = home;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        checks++;
        if (rq.size() != 0 || mq.size() != 0) begin
            errors++;
            $display("FAIL %s missing result: actual pending=%0d expected 0", r, rq.size() + mq.size());
            rq.delete();
            mq.delete();
        end
    endtask

    task automatic remote(input logic [17:0] tag, input logic [4:0] home, input string r);
        send(tag, home, 1'b1, {tag, OFF}, r);
    endtask

    task automatic redir(input logic [17:0] tag, input logic [4:0] home, input int slot, input string r);
        send(tag, home, 1'b0, RSV + 24'(slot * 64) + 24'(OFF), r);
    endtask

    task automatic expect_mig(input logic [17:0] tag, input logic [4:0] home, input int slot, input string r);
        mq.push_back('{tag, home, 4'(slot), r});
    endtask

    task automatic pulse_done();
        mig_done = 1'b1;
        @(negedge clk);
        mig_done = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] ta, tb_, tx;
        ta = 18'h100; tb_ = 18'h101; tx = 18'h3ff;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        sub_en = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || mig_req_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: actual ov=%0d mv=%0d expected 0 0", out_valid, mig_req_valid);
        end

        // R6: stray completion with nothing in flight installs nothing
        pulse_done();
        remote(ta, 5'd3, "R6");
        // R1: native block passes through unchanged
        send(18'h050, 5'd0, 1'b0, {18'h050, OFF}, "R1");
        // R3 then R4: fourth remote access triggers migration to slot 0
        remote(ta, 5'd3, "R3");
        remote(ta, 5'd3, "R3");
        expect_mig(ta, 5'd3, 0, "R4");
        remote(ta, 5'd3, "R4");
        // R5: still remote while in flight, no second request
        remote(ta, 5'd3, "R5");
        remote(ta, 5'd3, "R5");
        pulse_done();
        redir(ta, 5'd3, 0, "R6");
        redir(ta, 5'd3, 0, "R2");

        // R7: disabled policy, counting continues, entries keep redirecting
        sub_en = 1'b0;
        for (int i = 0; i < 5; i++) remote(tb_, 5'd7, "R7");
        redir(ta, 5'd3, 0, "R7");
        sub_en = 1'b1;
        expect_mig(tb_, 5'd7, 1, "R7");
        remote(tb_, 5'd7, "R7");
        pulse_done();
        redir(tb_, 5'd7, 1, "R2");

        // R8: flush drops all subscriptions
        pulse_flush();
        remote(ta, 5'd3, "R8");
        remote(tb_, 5'd7, "R8");

        // R9: fill every slot, then overflow
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 3; k++) remote(18'h200 + 18'(i), 5'd1, "R9");
            expect_mig(18'h200 + 18'(i), 5'd1, i, "R9");
            remote(18'h200 + 18'(i), 5'd1, "R9");
            pulse_done();
        end
        redir(18'h205, 5'd1, 5, "R9");
        for (int k = 0; k < 4; k++) remote(tx, 5'd2, "R9");
        remote(18'h200, 5'd1, "R9");
        redir(18'h201, 5'd1, 1, "R9");
        expect_mig(tx, 5'd2, 0, "R9");
        remote(tx, 5'd2, "R9");
        pulse_done();
        redir(tx, 5'd2, 0, "R9");

        repeat (2) @(negedge clk);
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule